// File: doc/BRIEF.md
# Cross-Domain Timer Control Register

This block is the bus-side control register of a timer/PWM peripheral whose counting core runs on its own clock. Software writes an enable bit, a software-reset bit and a two-bit dither resolution code through a plain register port. The written values read back in the next bus cycle. The requests that carry them into the core domain complete several cycles later. Two busy flags, one for the enable operation and one for the reset operation, tell software when the core has taken each request.

Each request crosses as a level toggle through a flop synchronizer. A small core-side agent applies the request and returns the toggle as its acknowledgment. A separate one-bit debug register is not touched by a software reset, and its value is passed to the core. The register port is a plain write strobe with a combinational read. It has no valid/ready handshake because nothing streams through it.

Register map (address on `addr`): 0 = control, 1 = busy status (read-only), 2 = debug. Control fields: bit 0 software reset, bit 1 enable, bits 6:5 dither code, bits 7 and 4:2 reserved.

Top module: `sync_ctrl_reg`

## Requirements
- R1: After reset, the control, busy and debug registers all read 0, and `core_enable`, `core_dither`, `core_rst_pulse` and `core_dbg` are 0.
- R2: An accepted control write with bit 0 clear stores bit 1 as enable and bits 6:5 as the dither code. Both read back at address 0 in the bus cycle after the write edge.
- R3: An accepted control write with bit 0 clear sets busy bit 1 (address 1) from the next bus cycle. The bit clears only after `core_enable` and `core_dither` carry the written values.
- R4: Control bits 7 and 4:2 always read 0, whatever was written to them.
- R5: A control write with bit 0 set discards the other fields of that write and clears enable and dither. Control bit 0 and busy bit 0 read 1 until the core has finished the reset, and then both clear together. The core then shows `core_enable` = 0 and `core_dither` = 0, after exactly one cycle of `core_rst_pulse`.
- R6: Writing 0 to control bit 0 starts no reset: busy bit 0 stays 0 and no `core_rst_pulse` occurs.
- R7: A control write made while either busy bit is set has no effect, and this includes a write with bit 0 set. The stored fields, the busy bits and the core outputs are left as they were.
- R8: The debug register (address 2, bit 0) can be written at any time and reads back at once. It keeps its value through a software reset, and its value reaches `core_dbg`.
- R9: The dither code is passed to the core unchanged: 0 means dithering off, and 1, 2 and 3 mean dithering spread over 16, 32 and 64 PWM frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 2 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| clk_core | input | 1 | Core clock |
| rst_core_n | input | 1 | Asynchronous active-low reset, core domain |
| core_enable | output | 1 | Enable as applied in the core domain |
| core_dither | output | 2 | Dither code as applied in the core domain |
| core_rst_pulse | output | 1 | One core-cycle pulse when a software reset is applied |
| core_dbg | output | 1 | Debug bit, synchronized to the core clock |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 instead of the default 2. The clocks are 125 MHz on the bus side and about 75 MHz on the core side, which are unrelated. The deeper chain and the slower core lengthen every busy window to many bus cycles. That leaves room to aim a second control write, including a software-reset write, into a window that is certainly still open. It also lets the bench confirm that no busy flag drops before the core outputs have settled.

// File: rtl/sync_ctrl_pkg.sv
package sync_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_BUSY = 2'd1;
  localparam logic [ADDR_W-1:0] A_DBG  = 2'd2;

  localparam int B_SWRST  = 0;
  localparam int B_ENABLE = 1;
  localparam int B_DITH_L = 5;
  localparam int B_DITH_H = 6;

  typedef enum logic [1:0] {
    DITH_OFF = 2'd0,
    DITH_16  = 2'd1,
    DITH_32  = 2'd2,
    DITH_64  = 2'd3
  } dith_e;
endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctrl_bus_regs.sv
module ctrl_bus_regs
  import sync_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              en_ack_s,
  input  logic              sw_ack_s,
  output logic              en_req_t,
  output logic              sw_req_t,
  output logic              en_val,
  output dith_e             dith_val,
  output logic              dbg_val
);
  logic en_busy, sw_busy, any_busy;
  logic wr_ctrl, wr_dbg, accept;
  logic unused_wbits;

  assign en_busy  = en_req_t ^ en_ack_s;
  assign sw_busy  = sw_req_t ^ sw_ack_s;
  assign any_busy = en_busy | sw_busy;
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_dbg   = wr_en && (addr == A_DBG);
  assign accept   = wr_ctrl && !any_busy;
  assign unused_wbits = ^{wdata[7], wdata[4:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_val   <= 1'b0;
      dith_val <= DITH_OFF;
      en_req_t <= 1'b0;
      sw_req_t <= 1'b0;
    end else if (accept) begin
      if (wdata[B_SWRST]) begin
        en_val   <= 1'b0;
        dith_val <= DITH_OFF;
        sw_req_t <= ~sw_req_t;
      end else begin
        en_val   <= wdata[B_ENABLE];
        dith_val <= dith_e'(wdata[B_DITH_H:B_DITH_L]);
        en_req_t <= ~en_req_t;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_val <= 1'b0;
    else if (wr_dbg) dbg_val <= wdata[0];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[B_SWRST]           = sw_busy;
        rdata[B_ENABLE]          = en_val;
        rdata[B_DITH_H:B_DITH_L] = dith_val;
      end
      A_BUSY: begin
        rdata[0] = sw_busy;
        rdata[1] = en_busy;
      end
      A_DBG:   rdata[0] = dbg_val;
      default: rdata = '0;
    endcase
  end

  // R3: an accepted enable write opens the enable busy window
  p_en_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wdata[B_SWRST]) |=> en_busy);

  // R5: a reset write clears the fields and opens the reset busy window
  p_swrst_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wdata[B_SWRST]) |=> (sw_busy && !en_val && dith_val == DITH_OFF));

  // R7: a write during a busy window leaves the fields unchanged
  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && any_busy) |=> ($stable(en_val) && $stable(dith_val)));

  // R8: no control write disturbs the debug bit
  p_dbg_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> $stable(dbg_val));

  // R7: never two requests in flight at once
  p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_busy && sw_busy));
endmodule

// File: rtl/ctrl_core_agent.sv
module ctrl_core_agent
  import sync_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_req_s,
  input  logic  sw_req_s,
  input  logic  en_val,
  input  dith_e dith_val,
  output logic  en_ack_t,
  output logic  sw_ack_t,
  output logic  core_enable,
  output dith_e core_dither,
  output logic  core_rst_pulse
);
  logic en_evt, sw_evt;

  // The acknowledge toggles double as the edge-detect history.
  assign en_evt = en_req_s ^ en_ack_t;
  assign sw_evt = sw_req_s ^ sw_ack_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ack_t       <= 1'b0;
      sw_ack_t       <= 1'b0;
      core_enable    <= 1'b0;
      core_dither    <= DITH_OFF;
      core_rst_pulse <= 1'b0;
    end else begin
      core_rst_pulse <= 1'b0;
      if (sw_evt) begin
        core_enable    <= 1'b0;
        core_dither    <= DITH_OFF;
        core_rst_pulse <= 1'b1;
        sw_ack_t       <= sw_req_s;
      end else if (en_evt) begin
        core_enable <= en_val;
        core_dither <= dith_val;
        en_ack_t    <= en_req_s;
      end
    end
  end

  // R5: the reset pulse lasts one core cycle
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_pulse |=> !core_rst_pulse);

  // R5: while the pulse is high the core is disabled with dithering off
  p_pulse_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_pulse |-> (!core_enable && core_dither == DITH_OFF));

  // R3: the core outputs only move when a request is taken
  p_core_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_evt && !sw_evt) |=> ($stable(core_enable) && $stable(core_dither)));
endmodule

// File: rtl/sync_ctrl_reg.sv
module sync_ctrl_reg
  import sync_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              rst_bus_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              clk_core,
  input  logic              rst_core_n,
  output logic              core_enable,
  output logic [1:0]        core_dither,
  output logic              core_rst_pulse,
  output logic              core_dbg
);
  localparam int TO_CORE_W = 3;
  localparam int TO_BUS_W  = 2;

  logic  en_req_t, sw_req_t, en_ack_t, sw_ack_t;
  logic  en_val, dbg_val;
  dith_e dith_val, core_dith_e;
  logic [TO_CORE_W-1:0] core_sync;
  logic [TO_BUS_W-1:0]  bus_sync;

  ctrl_bus_regs u_bus (
    .clk      (clk_bus),
    .rst_n    (rst_bus_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .en_ack_s (bus_sync[0]),
    .sw_ack_s (bus_sync[1]),
    .en_req_t (en_req_t),
    .sw_req_t (sw_req_t),
    .en_val   (en_val),
    .dith_val (dith_val),
    .dbg_val  (dbg_val)
  );

  tgl_sync #(.STAGES(SYNC_STAGES), .WIDTH(TO_CORE_W)) u_to_core (
    .clk   (clk_core),
    .rst_n (rst_core_n),
    .d     ({dbg_val, sw_req_t, en_req_t}),
    .q     (core_sync)
  );

  tgl_sync #(.STAGES(SYNC_STAGES), .WIDTH(TO_BUS_W)) u_to_bus (
    .clk   (clk_bus),
    .rst_n (rst_bus_n),
    .d     ({sw_ack_t, en_ack_t}),
    .q     (bus_sync)
  );

  ctrl_core_agent u_core (
    .clk            (clk_core),
    .rst_n          (rst_core_n),
    .en_req_s       (core_sync[0]),
    .sw_req_s       (core_sync[1]),
    .en_val         (en_val),
    .dith_val       (dith_val),
    .en_ack_t       (en_ack_t),
    .sw_ack_t       (sw_ack_t),
    .core_enable    (core_enable),
    .core_dither    (core_dith_e),
    .core_rst_pulse (core_rst_pulse)
  );

  assign core_dither = core_dith_e;
  assign core_dbg    = core_sync[2];
endmodule

// File: tb/test_sync_ctrl_reg.sv
`timescale 1ns/1ps
module test_sync_ctrl_reg;
  logic       clk_bus = 0, clk_core = 0;
  logic       rst_bus_n = 0, rst_core_n = 0;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       core_enable, core_rst_pulse, core_dbg;
  logic [1:0] core_dither;

  int checks = 0, failures = 0, pulses = 0;
  bit finished = 0;
  bit exp_en = 0;
  bit [1:0] exp_dith = 0;

  always #4 clk_bus = ~clk_bus;
  always #6.7 clk_core = ~clk_core;

  sync_ctrl_reg #(.SYNC_STAGES(3)) i_sync_ctrl_reg (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_core(clk_core), .rst_core_n(rst_core_n),
    .core_enable(core_enable), .core_dither(core_dither),
    .core_rst_pulse(core_rst_pulse), .core_dbg(core_dbg));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_core) if (core_rst_pulse) pulses++;

  // Reference comparison on every bus clock while the control register is addressed
  always @(negedge clk_bus) begin
    #2;
    if (rst_bus_n && addr == 2'd0) begin
      chk("R4 reserved bits", {rdata[7], rdata[4:2]}, 0);
      chk("R2 enable readback", rdata[1], exp_en);
      chk("R2 dither readback", rdata[6:5], exp_dith);
    end
  end

  // locked: the bench knows a busy window is open, so the write must be dropped
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit locked);
    @(negedge clk_bus);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk_bus);
    #1;
    if (a == 2'd0 && !locked) begin
      if (d[0]) begin exp_en = 0; exp_dith = 0; end
      else begin exp_en = d[1]; exp_dith = d[6:5]; end
    end
    @(negedge clk_bus);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    addr = 2'd1;
    while (n < 300) begin
      @(negedge clk_bus); #1;
      if (rdata[1:0] == 2'b00) break;
      n++;
    end
    chk({req, " busy clears"}, (n < 300) ? 1 : 0, 1);
  endtask

  initial begin
    logic [7:0] v;
    int p0;
    repeat (3) @(negedge clk_bus);
    rst_bus_n = 1; rst_core_n = 1;
    @(negedge clk_bus);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 busy", v, 0);
    rd(2'd2, v); chk("R1 dbg", v, 0);
    chk("R1 core outputs", {core_enable, core_dither, core_rst_pulse, core_dbg}, 0);

    // R2/R3: enable with dither code 1
    wr(2'd0, 8'h22, 0);
    rd(2'd0, v); chk("R2 immediate readback", v, 8'h22);
    rd(2'd1, v); chk("R3 enable busy set", v, 8'h02);
    wait_idle("R3");
    chk("R3 core_enable at clear", core_enable, 1);
    chk("R9 core_dither code 1", core_dither, 1);

    // R4: reserved bits written as ones
    wr(2'd0, 8'hFE, 0);
    rd(2'd0, v); chk("R4 readback masks reserved", v, 8'h62);
    wait_idle("R4");

    // R7: second write inside the enable busy window is dropped
    wr(2'd0, 8'h40, 0);
    wr(2'd0, 8'h02, 1);
    rd(2'd0, v); chk("R7 locked write dropped", v, 8'h40);
    wait_idle("R7");
    chk("R7 core_enable", core_enable, 0);
    chk("R7 core_dither", core_dither, 2);

    // R7: a reset write inside the enable busy window is dropped too
    p0 = pulses;
    wr(2'd0, 8'h02, 0);
    wr(2'd0, 8'h01, 1);
    rd(2'd1, v); chk("R7 no reset busy", v[0], 0);
    wait_idle("R7 swrst");
    chk("R7 core_enable kept", core_enable, 1);
    chk("R7 no reset pulse", pulses - p0, 0);

    // R8: debug bit
    wr(2'd2, 8'h01, 0);
    rd(2'd2, v); chk("R8 dbg readback", v, 1);

    // R5: software reset discards the rest of the write
    p0 = pulses;
    wr(2'd0, 8'h63, 0);
    rd(2'd0, v); chk("R5 ctrl during reset", v, 8'h01);
    rd(2'd1, v); chk("R5 reset busy", v, 8'h01);
    wait_idle("R5");
    rd(2'd0, v); chk("R5 ctrl after reset", v, 0);
    chk("R5 core_enable", core_enable, 0);
    chk("R5 core_dither", core_dither, 0);
    repeat (4) @(negedge clk_bus);
    chk("R5 one pulse", pulses - p0, 1);
    rd(2'd2, v); chk("R8 dbg kept through reset", v, 1);
    chk("R8 core_dbg", core_dbg, 1);

    // R6: bit 0 written as zero starts no reset
    p0 = pulses;
    wr(2'd0, 8'h42, 0);
    rd(2'd1, v); chk("R6 no reset busy", v[0], 0);
    wait_idle("R6");
    chk("R6 no pulse", pulses - p0, 0);
    chk("R6 core_enable", core_enable, 1);

    // R9: every dither code reaches the core unchanged
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, 8'(c << 5) | 8'h02, 0);
      wait_idle("R9");
      chk("R9 dither code", core_dither, c);
    end

    // R8: debug cleared
    wr(2'd2, 8'h00, 0);
    rd(2'd2, v); chk("R8 dbg clear", v, 0);
    repeat (12) @(negedge clk_bus);
    chk("R8 core_dbg clear", core_dbg, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_bus);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule